// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital control side of an 8-bit serial sampling converter. The converter has eleven external analog channels and one internal self-test channel. A host talks to it over four wires: an active-low chip select, a serial I/O clock, a serial address line, and a data line that drives only while the chip is selected. In each frame the host shifts in a 4-bit channel address and reads back the result of the previous conversion. The block then asks the analog side to sample and hold. It runs a conversion window of fixed length and latches the 8-bit code that the behavioural converter model presents on `conv_data`.

Everything runs on the system clock. Chip select passes through a synchronizer and is then qualified on a falling system-clock edge. The I/O clock and the address line are synchronized and oversampled, and their edges are detected in the system-clock domain. Because the host sends no data on a handshake, the interface is plain pins with no back-pressure. The host is expected to keep each I/O clock phase at least four system clocks long.

The chip-select low transition that starts a frame also aborts any conversion still running, and the result register then keeps its older value. The host may instead hold chip select low across frames. In that case it must leave the I/O clock low until the conversion ends, and its next I/O clock edges begin the next frame.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While chip select is recognized as high, `dout_en` is 0 and the block ignores `io_clk` and `addr_in`. `chan_sel` keeps its value, `sample_on` and `hold_pulse` stay 0, and no result bit is consumed.
- R2: When `cs_n` falls, it is recognized only after two system-clock rising edges followed by a falling edge. If `cs_n` is driven low just after a falling edge, `dout_en` is still 0 one cycle later and is 1 two cycles later.
- R3: When chip select is recognized, `dout` carries bit 7 (MSB) of the last completed result. Falling I/O clock edges 1 through 7 each move `dout` to the next lower bit, so the frame delivers bits 7 down to 0 in that order.
- R4: The channel address is sampled from `addr_in` on I/O rising edges 1 to 4, MSB first, as a positive-logic 4-bit code. `chan_sel` takes that code on the 4th falling edge. Codes 12 to 15 select channel 0, and `chan_sel` keeps its value between frames.
- R5: `sample_on` rises on the 4th I/O falling edge and falls on the 8th. `hold_pulse` is high for exactly one cycle per frame, at the 8th falling edge.
- R6: After the hold, `conv_busy` is high for exactly 36 system-clock cycles. When it falls, the result register loads `conv_data` for the held channel.
- R7: For channel code 11 the result register loads the self-test code 128 instead of `conv_data`. This code lies within the allowed window of 125 to 131.
- R8: A recognized chip-select low transition during a conversion ends it at once with `conv_busy` cleared. The result register keeps its older value, and that value is what the new frame shifts out.
- R9: With chip select held low through a conversion, `dout` shows the MSB of the new result once the conversion ends. The next I/O clock edges run a full new frame.
- R10: Raising chip select during a conversion does not stop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| io_clk | input | 1 | Serial I/O clock from the host |
| addr_in | input | 1 | Serial channel address, MSB first |
| conv_data | input | 8 | Code from the behavioural converter model for the selected channel |
| chan_sel | output | 4 | Channel selected for sampling (0 to 11) |
| sample_on | output | 1 | High while the selected input is being sampled |
| hold_pulse | output | 1 | One-cycle strobe that freezes the sample and starts conversion |
| conv_busy | output | 1 | High during the conversion window |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
Several properties are checked every cycle. The recognized chip select tracks the synchronized input. Sampling and strobes stay quiet and `chan_sel` holds while the chip is deselected. `chan_sel` never leaves the legal range. The hold strobe always closes an open sampling window. An abort clears the busy flag and leaves the result untouched, and the result changes only on a completed conversion, with the self-test code for channel 11. Other behaviours can only be shown by the bench's frames: the exact cycle at which chip select is recognized, the MSB-first order of the shifted bits, the 36-cycle window length, the remapping of codes 12 to 15, and back-to-back frames with chip select held low.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  // One system-clock view of the serial host pins after synchronization.
  typedef struct packed {
    logic rise;    // qualified rising edge of the I/O clock
    logic fall;    // qualified falling edge of the I/O clock
    logic bit_in;  // synchronized address bit, aligned with the edges
  } io_evt_t;

endpackage

// File: rtl/sar_ctrl_sync.sv
module sar_ctrl_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] st;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= RST_VAL;
      else        st <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {STAGES{RST_VAL}};
      else        st <= {st[STAGES-2:0], d};
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/sar_ctrl_frame.sv
module sar_ctrl_frame
  import sar_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RES_W     = 8,
  parameter int LAST_CHAN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              frame_start,
  input  io_evt_t           evt,
  input  logic              busy,
  input  logic              done,
  input  logic [RES_W-1:0]  result,
  output logic              dout,
  output logic [ADDR_W-1:0] chan_sel,
  output logic              sample_on,
  output logic              hold_pulse
);

  localparam int RC_W = $clog2(ADDR_W + 1);
  localparam int FC_W = $clog2(RES_W);
  localparam logic [RC_W-1:0]   RC_FULL   = RC_W'(ADDR_W);
  localparam logic [FC_W-1:0]   FC_SAMPLE = FC_W'(ADDR_W - 1);
  localparam logic [FC_W-1:0]   FC_HOLD   = FC_W'(RES_W - 1);
  localparam logic [ADDR_W-1:0] CH_LAST   = ADDR_W'(LAST_CHAN);

  logic [RC_W-1:0]   rise_cnt;
  logic [FC_W-1:0]   fall_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [RES_W-1:0]  out_sh;
  logic              gate;

  // Edges count only inside a frame and outside the conversion window.
  assign gate = active & ~frame_start & ~busy;

  function automatic logic [ADDR_W-1:0] map_chan(input logic [ADDR_W-1:0] a);
    return (a > CH_LAST) ? '0 : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      addr_sh    <= '0;
      chan_sel   <= '0;
      sample_on  <= 1'b0;
      hold_pulse <= 1'b0;
    end else begin
      hold_pulse <= 1'b0;
      if (!active || frame_start) begin
        rise_cnt  <= '0;
        fall_cnt  <= '0;
        sample_on <= 1'b0;
      end else if (gate) begin
        if (evt.rise && rise_cnt < RC_FULL) begin
          addr_sh  <= {addr_sh[ADDR_W-2:0], evt.bit_in};
          rise_cnt <= rise_cnt + 1'b1;
        end
        if (evt.fall) begin
          if (fall_cnt == FC_HOLD) begin
            sample_on  <= 1'b0;
            hold_pulse <= 1'b1;
            fall_cnt   <= '0;
            rise_cnt   <= '0;
          end else begin
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt == FC_SAMPLE) begin
              chan_sel  <= map_chan(addr_sh);
              sample_on <= 1'b1;
            end
          end
        end
      end
    end
  end

  // Output shifter: tracks the result while idle or on a finished conversion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh <= '0;
    end else if (!active || done) begin
      out_sh <= result;
    end else if (gate && evt.fall && fall_cnt != FC_HOLD) begin
      out_sh <= {out_sh[RES_W-2:0], 1'b0};
    end
  end

  assign dout = out_sh[RES_W-1];

  AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sel <= CH_LAST);  // R4
  AST_HOLD_CLOSES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |-> (!sample_on && $past(sample_on)));  // R5
  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |=> !hold_pulse);  // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!sample_on && !hold_pulse));  // R1
  AST_IDLE_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(chan_sel));  // R1

endmodule

// File: rtl/sar_ctrl_conv.sv
module sar_ctrl_conv #(
  parameter int ADDR_W        = 4,
  parameter int RES_W         = 8,
  parameter int CONV_CYCLES   = 36,
  parameter int SELFTEST_CHAN = 11,
  parameter int SELFTEST_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] chan,
  input  logic [RES_W-1:0]  conv_data,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result
);

  localparam int CW = $clog2(CONV_CYCLES);
  localparam logic [CW-1:0]     CNT_LAST = CW'(CONV_CYCLES - 1);
  localparam logic [ADDR_W-1:0] ST_CHAN  = ADDR_W'(SELFTEST_CHAN);
  localparam logic [RES_W-1:0]  ST_CODE  = RES_W'(SELFTEST_CODE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == CNT_LAST) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= (chan == ST_CHAN) ? ST_CODE : conv_data;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && $stable(result)));  // R8
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));  // R6
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(cnt) == CNT_LAST));  // R6
  AST_SELFTEST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chan == ST_CHAN) |-> result == ST_CODE);  // R7

endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int RES_W         = 8,
  parameter int CONV_CYCLES   = 36,
  parameter int SYNC_STAGES   = 2,
  parameter int LAST_CHAN     = 11,
  parameter int SELFTEST_CHAN = 11,
  parameter int SELFTEST_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              io_clk,
  input  logic              addr_in,
  input  logic [RES_W-1:0]  conv_data,
  output logic [ADDR_W-1:0] chan_sel,
  output logic              sample_on,
  output logic              hold_pulse,
  output logic              conv_busy,
  output logic              dout,
  output logic              dout_en
);

  logic       cs_s;
  logic [1:0] io_s;
  logic       cs_act_n;
  logic       active;
  logic       act_q;
  logic       io_q;
  logic       frame_start;
  logic       abort;
  logic       conv_done;
  io_evt_t    evt;
  logic [RES_W-1:0] result;

  sar_ctrl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
  );

  sar_ctrl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_io_sync (
    .clk(clk), .rst_n(rst_n), .d({io_clk, addr_in}), .q(io_s)
  );

  // Qualification on the falling edge after the synchronizer's rising edges.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cs_act_n <= 1'b1;
    else        cs_act_n <= cs_s;
  end

  assign active = ~cs_act_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      io_q  <= 1'b0;
    end else begin
      act_q <= active;
      io_q  <= io_s[1];
    end
  end

  assign frame_start = active & ~act_q;
  assign abort       = frame_start & conv_busy;

  always_comb begin
    evt.rise   = active & act_q &  io_s[1] & ~io_q;
    evt.fall   = active & act_q & ~io_s[1] &  io_q;
    evt.bit_in = io_s[0];
  end

  sar_ctrl_frame #(.ADDR_W(ADDR_W), .RES_W(RES_W), .LAST_CHAN(LAST_CHAN)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .frame_start(frame_start),
    .evt(evt), .busy(conv_busy), .done(conv_done), .result(result),
    .dout(dout), .chan_sel(chan_sel), .sample_on(sample_on),
    .hold_pulse(hold_pulse)
  );

  sar_ctrl_conv #(
    .ADDR_W(ADDR_W), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES),
    .SELFTEST_CHAN(SELFTEST_CHAN), .SELFTEST_CODE(SELFTEST_CODE)
  ) u_conv (
    .clk(clk), .rst_n(rst_n), .start(hold_pulse), .abort(abort),
    .chan(chan_sel), .conv_data(conv_data), .busy(conv_busy),
    .done(conv_done), .result(result)
  );

  assign dout_en = active;

  AST_CS_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act_n) |-> !cs_s);  // R2
  AST_CS_RELEASE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act_n) |-> cs_s);  // R1
  AST_OFF_NO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!evt.rise && !evt.fall));  // R1

endmodule

// File: tb/test_sar_serial_ctrl.sv
module test_sar_serial_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       io_clk;
  logic       addr_in;
  logic [7:0] conv_data;
  logic [3:0] chan_sel;
  logic       sample_on;
  logic       hold_pulse;
  logic       conv_busy;
  logic       dout;
  logic       dout_en;

  int errors = 0;
  int checks = 0;
  int hold_seen = 0;
  int busy_run = 0;
  int last_len = 0;
  logic [7:0] last_res = 8'd0;

  always #4 clk = ~clk;

  sar_serial_ctrl i_sar_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .addr_in(addr_in),
    .conv_data(conv_data), .chan_sel(chan_sel), .sample_on(sample_on),
    .hold_pulse(hold_pulse), .conv_busy(conv_busy), .dout(dout), .dout_en(dout_en)
  );

  // Behavioural converter model: a fixed code per channel.
  assign conv_data = 8'(int'(chan_sel) * 19 + 7);

  always @(posedge clk) begin
    if (hold_pulse) hold_seen++;
    if (conv_busy) busy_run++;
    else if (busy_run != 0) begin
      last_len = busy_run;
      busy_run = 0;
    end
  end

  function automatic logic [3:0] map_chan(input logic [3:0] a);
    return (a > 4'd11) ? 4'd0 : a;
  endfunction

  function automatic logic [7:0] exp_res(input logic [3:0] a);
    logic [3:0] ch;
    ch = map_chan(a);
    if (ch == 4'd11) return 8'd128;
    return 8'(int'(ch) * 19 + 7);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_frame(input logic [3:0] a, input logic [7:0] old);
    int h0;
    h0 = hold_seen;
    for (int k = 0; k < 8; k++) begin
      addr_in = (k < 4) ? a[3-k] : 1'($urandom % 2);
      cyc(2);
      chk("R3 dout bit", int'(dout), int'(old[7-k]));
      if (k == 0) chk("R3 dout_en", int'(dout_en), 1);
      io_clk = 1'b1;
      cyc(6);
      io_clk = 1'b0;
      cyc(6);
      if (k == 3) begin
        chk("R4 chan_sel", int'(chan_sel), int'(map_chan(a)));
        chk("R5 sample_on open", int'(sample_on), 1);
      end
    end
    chk("R5 sample_on closed", int'(sample_on), 0);
    chk("R5 hold pulses", hold_seen - h0, 1);
  endtask

  task automatic wait_conv(input logic [7:0] exp);
    int n;
    n = 0;
    while (conv_busy && n < 100) begin
      cyc(1);
      n++;
    end
    cyc(2);
    chk("R6 busy length", last_len, 36);
    last_res = exp;
  endtask

  task automatic full_frame(input logic [3:0] a);
    cs_n = 1'b0;
    cyc(6);
    shift_frame(a, last_res);
    cs_n = 1'b1;
    cyc(6);
    chk("R10 busy after cs high", int'(conv_busy), 1);
    wait_conv(exp_res(a));
    chk("R1 dout_en idle", int'(dout_en), 0);
  endtask

  task automatic held_pair(input logic [3:0] a, input logic [3:0] b);
    cs_n = 1'b0;
    cyc(6);
    shift_frame(a, last_res);
    wait_conv(exp_res(a));
    chk("R9 new msb", int'(dout), int'(last_res[7]));
    chk("R9 still driven", int'(dout_en), 1);
    shift_frame(b, last_res);
    cs_n = 1'b1;
    cyc(6);
    wait_conv(exp_res(b));
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] a;
    logic [3:0] b;
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    cs_n = 1'b1;
    io_clk = 1'b0;
    addr_in = 1'b0;
    cyc(5);
    chk("R1 reset dout_en", int'(dout_en), 0);
    chk("R6 reset busy", int'(conv_busy), 0);
    chk("R5 reset sample", int'(sample_on), 0);
    chk("R4 reset chan", int'(chan_sel), 0);
    rst_n = 1'b1;
    cyc(3);

    // R2: recognition timing of a chip-select fall
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk); #1;
    chk("R2 not yet recognized", int'(dout_en), 0);
    @(negedge clk); #1;
    chk("R2 recognized", int'(dout_en), 1);
    cyc(4);
    shift_frame(4'd3, last_res);
    cs_n = 1'b1;
    cyc(6);
    wait_conv(exp_res(4'd3));

    // R1: pins toggled while deselected have no effect
    for (int k = 0; k < 8; k++) begin
      addr_in = k[0];
      io_clk = 1'b1;
      cyc(6);
      chk("R1 dout_en off", int'(dout_en), 0);
      io_clk = 1'b0;
      cyc(6);
      chk("R1 no sampling", int'(sample_on), 0);
    end
    chk("R1 chan held", int'(chan_sel), 3);
    chk("R1 no conversion", int'(conv_busy), 0);
    full_frame(4'd9);

    // R7: self-test channel
    full_frame(4'd11);
    chk("R7 self-test code", int'(last_res), 128);
    chk("R7 code in window", int'(last_res >= 8'd125 && last_res <= 8'd131), 1);
    full_frame(4'd0);

    // R4: out-of-range codes map to channel 0
    full_frame(4'd13);
    full_frame(4'd15);
    full_frame(4'd6);

    // R8: abort by a new frame during conversion
    cs_n = 1'b0;
    cyc(6);
    shift_frame(4'd5, last_res);
    cs_n = 1'b1;
    cyc(10);
    chk("R8 converting before abort", int'(conv_busy), 1);
    cs_n = 1'b0;
    cyc(6);
    chk("R8 aborted", int'(conv_busy), 0);
    shift_frame(4'd2, last_res);
    cs_n = 1'b1;
    cyc(6);
    wait_conv(exp_res(4'd2));

    // R9: chip select held low across frames
    held_pair(4'd7, 4'd10);

    // mixed random frames
    for (int i = 0; i < 10; i++) begin
      a = 4'($urandom % 16);
      b = 4'($urandom % 16);
      if ($urandom % 3 == 0) held_pair(a, b);
      else full_frame(a);
    end
    full_frame(4'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule